// File: doc/BRIEF.md
# Region-Based Address Security Filter

This block decides, for every memory transaction offered on one of its filter inputs, whether the transaction may proceed. Each transaction carries an address, a read/write flag, a secure/non-secure flag and a 4-bit master ID for non-secure traffic. The block compares the address against a small table of programmable address windows. The window that matches decides the permission. Secure traffic is judged by two secure permission bits in the window. Non-secure traffic is judged by a per-master read mask and a per-master write mask.

Window 0 is a background window. It always covers the whole implemented address space and applies on every filter. Only its permission fields can be changed. The other windows take a programmable base and an inclusive top on a 4 KB grain, plus a mask that selects the filters they apply to. When windows overlap, the window with the highest number wins.

The window table sits behind a plain 32-bit register port with write strobe, address and write data. Read data is combinational from the address. Two read-only items sit on the same port: a build-configuration word and a 32-bit identification value.

Top module: `addr_guard`

## Requirements
- R1: After reset, window 0 has all permission bits clear and every other window has all filter-enable bits clear, so every transaction on every filter is denied.
- R2: Offset 0x000 reads the build configuration. Bits [4:0] hold (windows - 1), bits [13:8] hold (address width - 1), bits [25:24] hold (filters - 1), and all other bits are zero.
- R3: Offsets 0xFF0, 0xFF4, 0xFF8 and 0xFFC read the bytes 0x0D, 0xF0, 0x05 and 0xB1 in bits [7:0], with all upper bits zero. Read least significant byte first, these form 0xB105F00D.
- R4: Window 0 reads base 0, top equal to all ones over the address width, and filter enables all ones over the filter count. Writes to its base, its top or its filter-enable bits change neither its readback nor any decision.
- R5: A window matches when base <= address <= top. The low 12 bits of a written base are stored as 0 and those of a written top as 0xFFF, and they read back so. Bits above the address width read as zero.
- R6: When several enabled windows match an address on a filter, the highest-numbered one decides. Window 0 decides only when no other window matches.
- R7: For a secure transaction (nonsec = 0), attribute bit 30 of the deciding window permits reads and bit 31 permits writes. With both bits clear, every secure access is denied.
- R8: For a non-secure transaction with master ID n, bit n of the ID-access register (mask in bits [15:0]) permits reads. Bit 16+n permits writes.
- R9: Attribute bits [3:0] enable a window on filters 0 to 3, one bit per filter. A window whose bit is clear for a filter does not match on that filter. Bits beyond the filter count, and bits [29:4], read as zero.
- R10: resp_valid[f] is high exactly one cycle after txn_valid[f]. resp_permit[f] holds the decision in that cycle and is low whenever resp_valid[f] is low. The filters decide independently in the same cycle.
- R11: Window w's registers sit at 0x100 + 0x20*w. The offsets within a window are: base low +0x0, base high +0x4, top low +0x8, top high +0xC, attributes +0x10, ID access +0x14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset (word aligned) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| txn_valid | input | NUM_FILTERS | Transaction present, one bit per filter |
| txn_addr | input | NUM_FILTERS*ADDR_W | Transaction address per filter |
| txn_write | input | NUM_FILTERS | 1 = write, 0 = read |
| txn_nonsec | input | NUM_FILTERS | 1 = non-secure, 0 = secure |
| txn_mid | input | NUM_FILTERS*4 | Non-secure master ID per filter |
| resp_valid | output | NUM_FILTERS | Decision present |
| resp_permit | output | NUM_FILTERS | 1 = permitted, 0 = denied |

## Verification
The assertions assume that register offsets are word aligned, that reset is held high at the start and that transaction fields are driven whenever their valid bit is high. The stimulus drives only multiples of four on cfg_addr and drives every field whenever it raises a valid bit. The bench keeps its own copy of the window table as written through the port. It predicts each decision by scanning that copy from the highest window down. It then sweeps every filter, both directions, secure traffic and all sixteen master IDs. These sweeps cover window edges (base - 1, base, top, top + 1), nested overlaps and the top of the address space.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    localparam int MAX_WINDOWS  = 9;
    localparam int MAX_FILTERS  = 4;
    localparam int MAX_ADDR_W   = 64;
    localparam int MID_W        = 4;
    localparam int MID_N        = 1 << MID_W;
    localparam int GRAIN_BITS   = 12;

    localparam logic [11:0] OFS_BUILD    = 12'h000;
    localparam logic [11:0] OFS_WIN_BASE = 12'h100;
    localparam int          WIN_STRIDE   = 32;
    localparam logic [11:0] OFS_ID0      = 12'hFF0;
    localparam logic [11:0] OFS_ID1      = 12'hFF4;
    localparam logic [11:0] OFS_ID2      = 12'hFF8;
    localparam logic [11:0] OFS_ID3      = 12'hFFC;
    localparam logic [31:0] IDENT_WORD   = 32'hB105_F00D;

    typedef enum logic [2:0] {
        SL_BASE_LO, SL_BASE_HI, SL_TOP_LO, SL_TOP_HI, SL_ATTR, SL_IDACC, SL_NONE
    } slot_e;

    typedef struct packed {
        logic [MAX_ADDR_W-1:0]  base;
        logic [MAX_ADDR_W-1:0]  top;
        logic                   sec_wr;
        logic                   sec_rd;
        logic [MAX_FILTERS-1:0] fen;
        logic [MID_N-1:0]       wr_mask;
        logic [MID_N-1:0]       rd_mask;
    } window_t;

    function automatic slot_e slot_of(input logic [4:0] ofs);
        case (ofs)
            5'h00:   return SL_BASE_LO;
            5'h04:   return SL_BASE_HI;
            5'h08:   return SL_TOP_LO;
            5'h0C:   return SL_TOP_HI;
            5'h10:   return SL_ATTR;
            5'h14:   return SL_IDACC;
            default: return SL_NONE;
        endcase
    endfunction

    function automatic logic access_ok(input window_t w, input logic wr,
                                       input logic ns, input logic [MID_W-1:0] mid);
        if (!ns) return wr ? w.sec_wr : w.sec_rd;
        return wr ? w.wr_mask[mid] : w.rd_mask[mid];
    endfunction

    function automatic logic [31:0] attr_word(input window_t w);
        return {w.sec_wr, w.sec_rd, 26'b0, w.fen};
    endfunction

    function automatic logic [7:0] ident_byte(input logic [1:0] idx);
        return IDENT_WORD[8*idx +: 8];
    endfunction

endpackage

// File: rtl/addr_guard_regs.sv
module addr_guard_regs
    import addr_guard_pkg::*;
#(
    parameter int NUM_WINDOWS = 9,
    parameter int NUM_FILTERS = 4,
    parameter int ADDR_W      = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [11:0]                cfg_addr,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    output window_t [NUM_WINDOWS-1:0]  windows
);
    localparam int IDX_W = (NUM_WINDOWS > 1) ? $clog2(NUM_WINDOWS) : 1;
    localparam logic [MAX_ADDR_W-1:0] AMASK =
        (ADDR_W >= MAX_ADDR_W) ? {MAX_ADDR_W{1'b1}}
                               : ((64'd1 << ADDR_W) - 64'd1);
    localparam logic [MAX_FILTERS-1:0] FMASK = MAX_FILTERS'((1 << NUM_FILTERS) - 1);
    localparam logic [11:0] WIN_END = 12'(256 + WIN_STRIDE * NUM_WINDOWS);
    localparam logic [31:0] BUILD_WORD = {6'b0, 2'(NUM_FILTERS - 1), 10'b0,
                                          6'(ADDR_W - 1), 3'b0, 5'(NUM_WINDOWS - 1)};

    logic [11:0]      win_off;
    logic [IDX_W-1:0] sel_idx;
    logic             in_win;
    slot_e            slot;

    assign win_off = cfg_addr - OFS_WIN_BASE;
    assign sel_idx = win_off[5 +: IDX_W];
    assign in_win  = (cfg_addr >= OFS_WIN_BASE) && (cfg_addr < WIN_END);
    assign slot    = slot_of(cfg_addr[4:0]);

    for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
        logic             hit;
        logic             sec_rd_q, sec_wr_q;
        logic [MID_N-1:0] rdm_q, wrm_q;

        assign hit = cfg_wr && in_win && (sel_idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                sec_rd_q <= 1'b0;
                sec_wr_q <= 1'b0;
                rdm_q    <= '0;
                wrm_q    <= '0;
            end else if (hit) begin
                if (slot == SL_ATTR) begin
                    sec_rd_q <= cfg_wdata[30];
                    sec_wr_q <= cfg_wdata[31];
                end
                if (slot == SL_IDACC) begin
                    rdm_q <= cfg_wdata[15:0];
                    wrm_q <= cfg_wdata[31:16];
                end
            end
        end

        if (w == 0) begin : g_background
            assign windows[w] = '{base: '0, top: AMASK, sec_wr: sec_wr_q,
                                  sec_rd: sec_rd_q, fen: FMASK,
                                  wr_mask: wrm_q, rd_mask: rdm_q};
        end else begin : g_prog
            logic [MAX_ADDR_W-1:0]  base_q, top_q;
            logic [MAX_FILTERS-1:0] fen_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= '0;
                    top_q  <= 64'(12'hFFF);
                    fen_q  <= '0;
                end else if (hit) begin
                    case (slot)
                        SL_BASE_LO: base_q[31:0]  <= {cfg_wdata[31:GRAIN_BITS],
                                                      {GRAIN_BITS{1'b0}}} & AMASK[31:0];
                        SL_BASE_HI: base_q[63:32] <= cfg_wdata & AMASK[63:32];
                        SL_TOP_LO:  top_q[31:0]   <= {cfg_wdata[31:GRAIN_BITS],
                                                      {GRAIN_BITS{1'b1}}} & AMASK[31:0];
                        SL_TOP_HI:  top_q[63:32]  <= cfg_wdata & AMASK[63:32];
                        SL_ATTR:    fen_q         <= cfg_wdata[MAX_FILTERS-1:0] & FMASK;
                        default: ;
                    endcase
                end
            end

            assign windows[w] = '{base: base_q, top: top_q, sec_wr: sec_wr_q,
                                  sec_rd: sec_rd_q, fen: fen_q,
                                  wr_mask: wrm_q, rd_mask: rdm_q};
        end
    end

    window_t cur;

    always_comb begin
        cfg_rdata = '0;
        cur       = windows[0];
        if (in_win) begin
            cur = windows[sel_idx];
            case (slot)
                SL_BASE_LO: cfg_rdata = cur.base[31:0];
                SL_BASE_HI: cfg_rdata = cur.base[63:32];
                SL_TOP_LO:  cfg_rdata = cur.top[31:0];
                SL_TOP_HI:  cfg_rdata = cur.top[63:32];
                SL_ATTR:    cfg_rdata = attr_word(cur);
                SL_IDACC:   cfg_rdata = {cur.wr_mask, cur.rd_mask};
                default:    cfg_rdata = '0;
            endcase
        end else begin
            case (cfg_addr)
                OFS_BUILD: cfg_rdata = BUILD_WORD;
                OFS_ID0:   cfg_rdata = {24'b0, ident_byte(2'd0)};
                OFS_ID1:   cfg_rdata = {24'b0, ident_byte(2'd1)};
                OFS_ID2:   cfg_rdata = {24'b0, ident_byte(2'd2)};
                OFS_ID3:   cfg_rdata = {24'b0, ident_byte(2'd3)};
                default:   cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/addr_guard_match.sv
module addr_guard_match
    import addr_guard_pkg::*;
#(
    parameter int NUM_WINDOWS = 9,
    parameter int ADDR_W      = 40,
    parameter int FILTER_IDX  = 0
) (
    input  window_t [NUM_WINDOWS-1:0] windows,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic                      ns,
    input  logic [MID_W-1:0]          mid,
    output logic                      permit
);
    logic [MAX_ADDR_W-1:0] addr_ext;
    window_t               winner;

    assign addr_ext = MAX_ADDR_W'(addr);

    // Scan upward; a later (higher) match overrides, window 0 is the fallback.
    always_comb begin
        winner = windows[0];
        for (int w = 1; w < NUM_WINDOWS; w++) begin
            if (windows[w].fen[FILTER_IDX] &&
                (addr_ext >= windows[w].base) && (addr_ext <= windows[w].top))
                winner = windows[w];
        end
        permit = access_ok(winner, wr, ns, mid);
    end

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
#(
    parameter int NUM_WINDOWS = 9,
    parameter int NUM_FILTERS = 4,
    parameter int ADDR_W      = 40
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr,
    input  logic [11:0]                   cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    input  logic [NUM_FILTERS-1:0]        txn_valid,
    input  logic [NUM_FILTERS*ADDR_W-1:0] txn_addr,
    input  logic [NUM_FILTERS-1:0]        txn_write,
    input  logic [NUM_FILTERS-1:0]        txn_nonsec,
    input  logic [NUM_FILTERS*MID_W-1:0]  txn_mid,
    output logic [NUM_FILTERS-1:0]        resp_valid,
    output logic [NUM_FILTERS-1:0]        resp_permit
);
    window_t [NUM_WINDOWS-1:0] windows;
    logic    [NUM_FILTERS-1:0] decide;

    addr_guard_regs #(
        .NUM_WINDOWS(NUM_WINDOWS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .windows(windows)
    );

    for (genvar f = 0; f < NUM_FILTERS; f++) begin : g_filter
        addr_guard_match #(
            .NUM_WINDOWS(NUM_WINDOWS), .ADDR_W(ADDR_W), .FILTER_IDX(f)
        ) u_match (
            .windows(windows),
            .addr(txn_addr[f*ADDR_W +: ADDR_W]),
            .wr(txn_write[f]),
            .ns(txn_nonsec[f]),
            .mid(txn_mid[f*MID_W +: MID_W]),
            .permit(decide[f])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= '0;
            resp_permit <= '0;
        end else begin
            resp_valid  <= txn_valid;
            resp_permit <= txn_valid & decide;
        end
    end

endmodule

// File: rtl/addr_guard_chk.sv
module addr_guard_chk
    import addr_guard_pkg::*;
#(
    parameter int NUM_WINDOWS = 9,
    parameter int NUM_FILTERS = 4,
    parameter int ADDR_W      = 40
) (
    input logic                   clk,
    input logic                   rst,
    input logic [11:0]            cfg_addr,
    input logic [31:0]            cfg_rdata,
    input logic [NUM_FILTERS-1:0] txn_valid,
    input logic [NUM_FILTERS-1:0] resp_valid,
    input logic [NUM_FILTERS-1:0] resp_permit
);
    localparam logic [11:0] WIN_END = 12'(256 + 32 * NUM_WINDOWS);
    logic in_win;
    assign in_win = (cfg_addr >= 12'h100) && (cfg_addr < WIN_END);

    for (genvar f = 0; f < NUM_FILTERS; f++) begin : g_f
        a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
            txn_valid[f] |=> resp_valid[f]);
        a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
            !txn_valid[f] |=> !resp_valid[f]);
        a_r10_idle_no_permit: assert property (@(posedge clk) disable iff (rst)
            !resp_valid[f] |-> !resp_permit[f]);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> (resp_valid == '0) && (resp_permit == '0));

    a_r2_build_fields: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 12'h000) |-> (cfg_rdata[4:0] == 5'(NUM_WINDOWS - 1)) &&
                                  (cfg_rdata[13:8] == 6'(ADDR_W - 1)));

    a_r3_ident_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr[11:4] == 8'hFF) |-> (cfg_rdata[31:8] == 24'b0));

    a_r4_background_base: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 12'h100) |-> (cfg_rdata == 32'b0));

    a_r5_base_grain: assert property (@(posedge clk) disable iff (rst)
        (in_win && cfg_addr[4:0] == 5'h00) |-> (cfg_rdata[11:0] == 12'h000));

    a_r5_top_grain: assert property (@(posedge clk) disable iff (rst)
        (in_win && cfg_addr[4:0] == 5'h08) |-> (cfg_rdata[11:0] == 12'hFFF));

    a_r9_attr_reserved: assert property (@(posedge clk) disable iff (rst)
        (in_win && cfg_addr[4:0] == 5'h10) |-> (cfg_rdata[29:NUM_FILTERS] == '0));

endmodule

bind addr_guard addr_guard_chk #(
    .NUM_WINDOWS(NUM_WINDOWS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .txn_valid(txn_valid), .resp_valid(resp_valid), .resp_permit(resp_permit)
);

// File: tb/addr_guard_test.sv
`timescale 1ns/1ps
module addr_guard_test;
    localparam int NW = 9;
    localparam int NF = 4;
    localparam int AW = 40;
    localparam logic [63:0] AMASK = (64'd1 << AW) - 64'd1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [11:0]      cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic [NF-1:0]    txn_valid = '0;
    logic [NF*AW-1:0] txn_addr = '0;
    logic [NF-1:0]    txn_write = '0;
    logic [NF-1:0]    txn_nonsec = '0;
    logic [NF*4-1:0]  txn_mid = '0;
    logic [NF-1:0]    resp_valid, resp_permit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [63:0] m_base [NW];
    logic [63:0] m_top  [NW];
    logic [1:0]  m_sec  [NW];
    logic [3:0]  m_fen  [NW];
    logic [31:0] m_idm  [NW];

    always #2.5 clk = ~clk;

    addr_guard #(.NUM_WINDOWS(NW), .NUM_FILTERS(NF), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_write(txn_write), .txn_nonsec(txn_nonsec),
        .txn_mid(txn_mid), .resp_valid(resp_valid), .resp_permit(resp_permit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, 64'(cfg_rdata), 64'(exp));
    endtask

    function automatic logic [11:0] wofs(input int w, input int s);
        return 12'(256 + 32 * w + s);
    endfunction

    // Program one window and mirror the effect in the bench model.
    task automatic set_window(input int w, input logic [63:0] b, input logic [63:0] t,
                              input logic [3:0] fen, input logic [1:0] sec,
                              input logic [31:0] idm);
        wr_reg(wofs(w, 'h00), b[31:0]);
        wr_reg(wofs(w, 'h04), b[63:32]);
        wr_reg(wofs(w, 'h08), t[31:0]);
        wr_reg(wofs(w, 'h0C), t[63:32]);
        wr_reg(wofs(w, 'h10), {sec, 26'b0, fen});
        wr_reg(wofs(w, 'h14), idm);
        if (w != 0) begin
            m_base[w] = {b[63:12], 12'h000} & AMASK;
            m_top[w]  = {t[63:12], 12'hFFF} & AMASK;
            m_fen[w]  = fen;
        end
        m_sec[w] = sec;
        m_idm[w] = idm;
    endtask

    function automatic logic expect_permit(input int f, input logic [63:0] a,
                                           input logic w, input logic ns,
                                           input logic [3:0] id);
        int win = 0;
        for (int r = 1; r < NW; r++)
            if (m_fen[r][f] && a >= m_base[r] && a <= m_top[r]) win = r;
        if (!ns) return w ? m_sec[win][1] : m_sec[win][0];
        return w ? m_idm[win][16 + int'(id)] : m_idm[win][int'(id)];
    endfunction

    task automatic one_txn(input string req, input int f, input logic [63:0] a,
                           input logic w, input logic ns, input logic [3:0] id);
        @(negedge clk);
        txn_valid[f] = 1'b1;
        txn_addr[f*AW +: AW] = a[AW-1:0];
        txn_write[f] = w; txn_nonsec[f] = ns; txn_mid[f*4 +: 4] = id;
        @(negedge clk);
        txn_valid[f] = 1'b0;
        check({req, " valid"}, 64'(resp_valid[f]), 64'd1);
        check(req, 64'(resp_permit[f]), 64'(expect_permit(f, a, w, ns, id)));
    endtask

    task automatic sweep(input string req, input logic [63:0] a);
        for (int f = 0; f < NF; f++) begin
            for (int w = 0; w < 2; w++) begin
                one_txn(req, f, a, w[0], 1'b0, 4'd0);
                for (int id = 0; id < 16; id++)
                    one_txn(req, f, a, w[0], 1'b1, 4'(id));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NW; r++) begin
            m_base[r] = '0; m_top[r] = 64'hFFF; m_sec[r] = '0; m_fen[r] = '0; m_idm[r] = '0;
        end
        m_top[0] = AMASK; m_fen[0] = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: nothing passes after reset; idle filters report nothing (R10)
        #1;
        check("R1 resp idle after reset", 64'(resp_valid), 64'd0);
        sweep("R1", 64'h0000_1000);
        sweep("R1", AMASK);

        // R2 / R3: identification words
        rd_check("R2 build config", 12'h000, 32'h0300_2708);
        rd_check("R3 ident byte0", 12'hFF0, 32'h0D);
        rd_check("R3 ident byte1", 12'hFF4, 32'hF0);
        rd_check("R3 ident byte2", 12'hFF8, 32'h05);
        rd_check("R3 ident byte3", 12'hFFC, 32'hB1);
        rd_check("R3 unmapped zero", 12'hFE0, 32'h0);

        // R4: background window is fixed except permissions
        wr_reg(wofs(0, 'h00), 32'h0000_5000);
        wr_reg(wofs(0, 'h08), 32'h0000_8FFF);
        wr_reg(wofs(0, 'h0C), 32'h0);
        rd_check("R4 bg base lo", wofs(0, 'h00), 32'h0);
        rd_check("R4 bg base hi", wofs(0, 'h04), 32'h0);
        rd_check("R4 bg top lo", wofs(0, 'h08), 32'hFFFF_FFFF);
        rd_check("R4 bg top hi", wofs(0, 'h0C), 32'h0000_00FF);
        set_window(0, 64'h0, 64'h0, 4'h0, 2'b01, 32'h0020_0008);
        rd_check("R4 bg fen fixed", wofs(0, 'h10), 32'h4000_000F);
        // R7 / R8 on the background window: secure read only, ns read id3, ns write id5
        sweep("R7 R8 background", 64'h0000_9000);
        sweep("R4 bg beyond rewritten top", 64'h00F0_0000_0000);

        // R11: each window's registers at its own stride
        for (int r = 1; r < NW; r++) begin
            wr_reg(wofs(r, 'h14), 32'(r) * 32'h1357_9BDF);
            m_idm[r] = 32'(r) * 32'h1357_9BDF;
        end
        for (int r = 1; r < NW; r++)
            rd_check("R11 id access stride", wofs(r, 'h14), 32'(r) * 32'h1357_9BDF);
        wr_reg(wofs(5, 'h10), 32'hFFFF_FFFF);
        m_sec[5] = 2'b11; m_fen[5] = 4'hF;
        rd_check("R9 attr reserved bits", wofs(5, 'h10), 32'hC000_000F);
        wr_reg(wofs(5, 'h10), 32'h0);
        m_sec[5] = 2'b00; m_fen[5] = 4'h0;

        // R5 / R9: window 1 on filter 0 only, grain forcing on readback
        set_window(1, 64'h0000_0000_0010_0123, 64'h0000_0000_001F_F000, 4'b0001, 2'b10,
                   32'h0000_FFFF);
        rd_check("R5 base grain", wofs(1, 'h00), 32'h0010_0000);
        rd_check("R5 top grain", wofs(1, 'h08), 32'h001F_FFFF);
        wr_reg(wofs(1, 'h04), 32'hFFFF_FFFF);
        rd_check("R5 base hi width", wofs(1, 'h04), 32'h0000_00FF);
        wr_reg(wofs(1, 'h04), 32'h0);
        sweep("R5 below base", 64'h000F_FFFF);
        sweep("R5 at base", 64'h0010_0000);
        sweep("R5 at top", 64'h001F_FFFF);
        sweep("R5 above top", 64'h0020_0000);

        // R6: nested windows, highest number wins
        set_window(2, 64'h0018_0000, 64'h0018_0FFF, 4'b0011, 2'b11, 32'h0080_0080);
        set_window(8, 64'h0018_0000, 64'h0018_0FFF, 4'b0001, 2'b00, 32'h0);
        sweep("R6 three deep", 64'h0018_0800);
        sweep("R6 edge of inner", 64'h0018_1000);
        set_window(8, 64'h0018_0000, 64'h0018_0FFF, 4'b0000, 2'b00, 32'h0);
        sweep("R6 R9 inner disabled", 64'h0018_0000);

        // R5: window at the top of the address space
        set_window(3, 64'h80_0000_0000, 64'hFF_FFFF_FFFF, 4'b1111, 2'b01, 32'hFFFF_0000);
        sweep("R5 high window", 64'h80_0000_0000);
        sweep("R5 under high window", 64'h7F_FFFF_FFFF);
        sweep("R5 last address", AMASK);

        // R10: all filters in the same cycle, each with its own decision
        @(negedge clk);
        txn_valid = '1;
        txn_write = 4'b0101; txn_nonsec = 4'b0011;
        txn_mid = {4'd2, 4'd9, 4'd7, 4'd3};
        txn_addr = {40'h80_0000_0000, 40'h18_0000, 40'h18_0000, 40'h10_0000};
        @(negedge clk);
        txn_valid = '0;
        check("R10 all valid", 64'(resp_valid), 64'hF);
        check("R10 filter0", 64'(resp_permit[0]), 64'(expect_permit(0, 64'h10_0000, 1'b1, 1'b1, 4'd3)));
        check("R10 filter1", 64'(resp_permit[1]), 64'(expect_permit(1, 64'h18_0000, 1'b0, 1'b1, 4'd7)));
        check("R10 filter2", 64'(resp_permit[2]), 64'(expect_permit(2, 64'h18_0000, 1'b1, 1'b0, 4'd9)));
        check("R10 filter3", 64'(resp_permit[3]), 64'(expect_permit(3, 64'h80_0000_0000, 1'b0, 1'b0, 4'd2)));
        @(negedge clk);
        check("R10 idle after", 64'({resp_valid, resp_permit}), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule